// File: doc/BRIEF.md
# SD Card Data Length and Timeout Counter

This block holds the two values software sets up before a memory-card data transfer: a byte count and a wait limit measured in card clock periods. A start pulse from the data-control write copies the byte count into a down-counter. The counter then goes down as the data engine hands over beats through a valid/ready handshake. A second down-counter measures every phase in which the data engine waits, either for data or for the card to release busy. If that counter runs out, the block stops the transfer and raises a sticky timeout flag.

When a transfer starts, the block also applies the rules for the count. In double-data-rate mode the count is rounded down to an even number. A count that is zero after rounding aborts the request and clears both the data enable and the command enable. A count that does not suit the chosen transfer mode raises a configuration error, and no transfer begins. While a transfer is running, writes to the length register are dropped. Writes to the timeout register are also dropped while the command engine is busy.

The beat interface follows valid/ready rules. `beat_ready` equals `data_en`. A beat counts only in a cycle where both `beat_valid` and `beat_ready` are high. The data engine applies back-pressure simply by holding `beat_valid` low, and a cycle with no handshake leaves the count unchanged.

Top module: `sd_xfer_counter`

## Requirements
- R1: A synchronous active-high reset clears both registers, the data counter, the timeout counter, `data_en`, `cmd_en`, `done`, `timeout_flag` and `cfg_err` to zero.
- R2: `reg_wr` with `reg_sel`=0 writes the length register. Only bits 24:0 are stored, and `len_rdata` reads bits 31:25 as zero. The write is ignored while `data_en` is 1.
- R3: `reg_wr` with `reg_sel`=1 writes the 32-bit timeout register, which reads back on `tmo_rdata`. The write is ignored while `data_en` or `cmd_active` is 1.
- R4: `start_data` while idle, with a legal non-zero effective length, sets `data_en` and loads `cnt_rdata` with the effective length at the next clock edge. The effective length is the length register in single-rate mode. When `ddr_mode`=1 it is the length register with bit 0 cleared.
- R5: Each handshake (`beat_valid` and `beat_ready` both 1) lowers the counter by 1 in single-rate mode, or by 2 when the transfer was started with `ddr_mode`=1. A cycle with no handshake leaves it unchanged, and `beat_ready` equals `data_en`.
- R6: The handshake that brings the counter to zero drops `data_en` and raises `done` for exactly one cycle at the same clock edge.
- R7: When the effective length is zero, `start_data` starts no transfer and clears `data_en` and `cmd_en`. `start_cmd` with `cmd_xfer`=1 under a zero effective length leaves `cmd_en` at 0.
- R8: Length legality depends on the mode. With `block_mode`=1 the effective length must be a multiple of 2^`blk_log2`. With `block_mode`=0 it must not exceed 512. A non-zero illegal length at `start_data` sets `cfg_err` and starts nothing. Any idle `start_data` first clears `cfg_err` and `timeout_flag`.
- R9: While `wait_phase` is 0 the timeout counter reloads from the timeout register. After T consecutive cycles with `wait_phase`=1 (T=0 counts as 1), `timeout_flag` becomes 1 and `data_en` falls. The flag stays set until the next idle `start_data`.
- R10: `start_data` while `data_en` is 1 is ignored, and the counter keeps its value.
- R11: `start_cmd` sets `cmd_en` unless R7 blocks it, and `cmd_taken` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects length, 1 selects timeout |
| reg_wdata | input | 32 | Register write data |
| len_rdata | output | 32 | Length register readback |
| tmo_rdata | output | 32 | Timeout register readback |
| start_data | input | 1 | Data-control write requesting a transfer |
| ddr_mode | input | 1 | Double-data-rate mode |
| block_mode | input | 1 | 1 selects block mode, 0 selects multibyte mode |
| blk_log2 | input | 4 | Block size exponent |
| start_cmd | input | 1 | Command enable request |
| cmd_xfer | input | 1 | The command carries a data transfer |
| cmd_taken | input | 1 | The command engine has accepted the enable |
| cmd_active | input | 1 | The command engine is busy |
| wait_phase | input | 1 | The data engine is waiting for data or busy release |
| beat_valid | input | 1 | The data engine offers a beat |
| beat_ready | output | 1 | The block accepts a beat |
| cnt_rdata | output | 25 | Current data counter value |
| data_en | output | 1 | A transfer is active |
| cmd_en | output | 1 | Command enable |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| timeout_flag | output | 1 | Sticky timeout |
| cfg_err | output | 1 | Sticky illegal-length flag |

## Verification
The length sweep covers every count from 0 to 40 in both data rates. Beats arrive with a gap on every third cycle, so decrementing only on a handshake is distinguished from decrementing on every cycle, and the even and odd counts in double-data-rate mode expose the rounding. A second sweep combines block exponents 0 to 3 with lengths 0 to 16, which separates legal from illegal multiples in each mode. The 512/513 boundary is also tried in single-rate and double-data-rate mode. Timeout values from 0 to 5 are tested with an unbroken wait, and one run breaks the wait partway through. Together these pin down the expiry cycle and show that the counter reloads. Separate runs aim writes at the busy phases and send start requests with a zero count, to confirm that the locks and the abort path work.

// File: rtl/sdxc_pkg.sv
package sdxc_pkg;
  typedef enum logic {
    SEL_LEN = 1'b0,
    SEL_TMO = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sdxc_regs.sv
module sdxc_regs #(
  parameter int LEN_W = 25,
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic             data_busy,
  input  logic             cmd_busy,
  output logic [LEN_W-1:0] len_q,
  output logic [TMO_W-1:0] tmo_q
);
  import sdxc_pkg::*;

  logic len_we, tmo_we;
  assign len_we = reg_wr && (reg_sel_e'(reg_sel) == SEL_LEN) && !data_busy;
  assign tmo_we = reg_wr && (reg_sel_e'(reg_sel) == SEL_TMO) && !data_busy && !cmd_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      tmo_q <= '0;
    end else begin
      if (len_we) len_q <= reg_wdata[LEN_W-1:0];
      if (tmo_we) tmo_q <= reg_wdata[TMO_W-1:0];
    end
  end

  // R2: length held while a transfer runs
  assert_len_lock_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 1'b0 && data_busy) |=> $stable(len_q));
  // R3: timeout held while either engine is busy
  assert_tmo_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 1'b1 && (data_busy || cmd_busy)) |=> $stable(tmo_q));
endmodule

// File: rtl/sdxc_tmocnt.sv
module sdxc_tmocnt #(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMO_W-1:0] tmo_q,
  input  logic             wait_phase,
  input  logic             clr_flag,
  output logic             expire,
  output logic             flag
);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt;

  assign expire = wait_phase && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (!wait_phase)    cnt <= tmo_q;
      else if (cnt > ONE) cnt <= cnt - ONE;
      else                cnt <= '0;
      if (expire)        flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end

  // R9: one step per waiting cycle
  assert_tmo_step_R9: assert property (@(posedge clk) disable iff (rst)
    (wait_phase && cnt > ONE) |=> (cnt == $past(cnt) - ONE));
  // R9: expiry always leaves the sticky flag set
  assert_tmo_flag_R9: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);
endmodule

// File: rtl/sdxc_datacnt.sv
module sdxc_datacnt #(
  parameter int LEN_W  = 25,
  parameter int BLK_W  = 4,
  parameter int MB_MAX = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_q,
  input  logic             start_data,
  input  logic             ddr_mode,
  input  logic             block_mode,
  input  logic [BLK_W-1:0] blk_log2,
  input  logic             beat_valid,
  input  logic             tmo_expire,
  output logic [LEN_W-1:0] cnt_q,
  output logic             active,
  output logic             done,
  output logic             cfg_err,
  output logic             take,
  output logic             eff_zero
);
  localparam logic [LEN_W-1:0] MB_LIM = LEN_W'(MB_MAX);
  localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO    = LEN_W'(2);

  logic [LEN_W-1:0] eff, blk_mask, step;
  logic             illegal, go, fire, ddr_q;

  assign eff      = ddr_mode ? {len_q[LEN_W-1:1], 1'b0} : len_q;
  assign blk_mask = ~({LEN_W{1'b1}} << blk_log2);
  assign illegal  = block_mode ? (|(eff & blk_mask)) : (eff > MB_LIM);
  assign eff_zero = (eff == '0);
  assign take     = start_data && !active;
  assign go       = take && !eff_zero && !illegal;
  assign step     = ddr_q ? TWO : ONE;
  assign fire     = active && beat_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      active  <= 1'b0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
      ddr_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) cfg_err <= !eff_zero && illegal;
      if (go) begin
        cnt_q  <= eff;
        active <= 1'b1;
        ddr_q  <= ddr_mode;
      end else if (active) begin
        if (tmo_expire) begin
          active <= 1'b0;
        end else if (fire) begin
          if (cnt_q <= step) begin
            cnt_q  <= '0;
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - step;
          end
        end
      end
    end
  end

  // R5: single-rate handshake lowers the count by one
  assert_sdr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && !tmo_expire && !ddr_q && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
  // R5: no handshake, no change
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (active && !beat_valid && !tmo_expire) |=> $stable(cnt_q));
  // R4: a double-rate count is always even
  assert_ddr_even_R4: assert property (@(posedge clk) disable iff (rst)
    (active && ddr_q) |-> !cnt_q[0]);
  // R6: done is a single pulse with the transfer finished
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && cnt_q == '0) ##1 !done);
  // R10: start while busy keeps the count
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    (start_data && active && !fire && !tmo_expire) |=> $stable(cnt_q));
endmodule

// File: rtl/sd_xfer_counter.sv
module sd_xfer_counter #(
  parameter int LEN_W  = 25,
  parameter int TMO_W  = 32,
  parameter int BLK_W  = 4,
  parameter int MB_MAX = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      len_rdata,
  output logic [31:0]      tmo_rdata,
  input  logic             start_data,
  input  logic             ddr_mode,
  input  logic             block_mode,
  input  logic [BLK_W-1:0] blk_log2,
  input  logic             start_cmd,
  input  logic             cmd_xfer,
  input  logic             cmd_taken,
  input  logic             cmd_active,
  input  logic             wait_phase,
  input  logic             beat_valid,
  output logic             beat_ready,
  output logic [LEN_W-1:0] cnt_rdata,
  output logic             data_en,
  output logic             cmd_en,
  output logic             done,
  output logic             timeout_flag,
  output logic             cfg_err
);
  logic [LEN_W-1:0] len_q;
  logic [TMO_W-1:0] tmo_q;
  logic             active, take, eff_zero, tmo_expire, abort_cmd;

  sdxc_regs #(.LEN_W(LEN_W), .TMO_W(TMO_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .data_busy(active), .cmd_busy(cmd_active),
    .len_q(len_q), .tmo_q(tmo_q)
  );

  sdxc_tmocnt #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .tmo_q(tmo_q), .wait_phase(wait_phase),
    .clr_flag(take), .expire(tmo_expire), .flag(timeout_flag)
  );

  sdxc_datacnt #(.LEN_W(LEN_W), .BLK_W(BLK_W), .MB_MAX(MB_MAX)) u_cnt (
    .clk(clk), .rst(rst), .len_q(len_q), .start_data(start_data),
    .ddr_mode(ddr_mode), .block_mode(block_mode), .blk_log2(blk_log2),
    .beat_valid(beat_valid), .tmo_expire(tmo_expire), .cnt_q(cnt_rdata),
    .active(active), .done(done), .cfg_err(cfg_err), .take(take),
    .eff_zero(eff_zero)
  );

  assign abort_cmd = (take && eff_zero) || (start_cmd && cmd_xfer && eff_zero);

  always_ff @(posedge clk) begin
    if (rst)            cmd_en <= 1'b0;
    else if (abort_cmd) cmd_en <= 1'b0;
    else if (start_cmd) cmd_en <= 1'b1;
    else if (cmd_taken) cmd_en <= 1'b0;
  end

  assign len_rdata  = 32'(len_q);
  assign tmo_rdata  = 32'(tmo_q);
  assign data_en    = active;
  assign beat_ready = active;

  // R7: a zero-length start leaves both enables low
  assert_zero_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (start_data && !data_en && eff_zero) |=> (!data_en && !cmd_en));
  // R9: a fresh timeout never coexists with a running transfer
  assert_tmo_stop_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> !data_en);
  // R11: acceptance clears the command enable
  assert_cmd_taken_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_taken && !start_cmd) |=> !cmd_en);
endmodule

// File: tb/sd_xfer_counter_test.sv
module sd_xfer_counter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, reg_wr, reg_sel, start_data, ddr_mode, block_mode;
  logic [31:0] reg_wdata, len_rdata, tmo_rdata;
  logic [3:0]  blk_log2;
  logic        start_cmd, cmd_xfer, cmd_taken, cmd_active, wait_phase, beat_valid;
  logic        beat_ready, data_en, cmd_en, done, timeout_flag, cfg_err;
  logic [24:0] cnt_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_xfer_counter uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .len_rdata(len_rdata), .tmo_rdata(tmo_rdata), .start_data(start_data),
    .ddr_mode(ddr_mode), .block_mode(block_mode), .blk_log2(blk_log2),
    .start_cmd(start_cmd), .cmd_xfer(cmd_xfer), .cmd_taken(cmd_taken),
    .cmd_active(cmd_active), .wait_phase(wait_phase), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .cnt_rdata(cnt_rdata), .data_en(data_en),
    .cmd_en(cmd_en), .done(done), .timeout_flag(timeout_flag), .cfg_err(cfg_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    start_data = 1'b1;
    tick();
    start_data = 1'b0;
  endtask

  // full transfer with a gap on every third beat
  task automatic run_xfer(input int len, input bit ddr, input bit blk, input int k);
    int eff, step, rem, i;
    bit bad;
    eff  = ddr ? (len & ~1) : len;
    step = ddr ? 2 : 1;
    bad  = blk ? ((eff % (1 << k)) != 0) : (eff > 512);
    wr_reg(1'b0, 32'(len));
    ddr_mode = ddr; block_mode = blk; blk_log2 = 4'(k);
    pulse_start();
    if (eff == 0) begin
      chk("R7 zero length data_en", data_en, 0);
      chk("R7 zero length cfg_err", cfg_err, 0);
    end else if (bad) begin
      chk("R8 illegal cfg_err", cfg_err, 1);
      chk("R8 illegal data_en", data_en, 0);
    end else begin
      chk("R8 legal cfg_err", cfg_err, 0);
      chk("R4 data_en", data_en, 1);
      chk("R4 loaded count", cnt_rdata, eff);
      rem = eff; i = 0;
      while (rem > 0) begin
        beat_valid = ((i % 3) != 2);
        tick();
        if (beat_valid) rem -= step;
        i++;
        if (rem > 0) chk("R5 count", cnt_rdata, rem);
        else begin
          chk("R6 done", done, 1);
          chk("R6 data_en low", data_en, 0);
          chk("R6 count zero", cnt_rdata, 0);
        end
      end
      beat_valid = 1'b0;
      tick();
      chk("R6 done single", done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_wr = 0; reg_sel = 0; reg_wdata = 0; start_data = 0;
    ddr_mode = 0; block_mode = 0; blk_log2 = 0; start_cmd = 0; cmd_xfer = 0;
    cmd_taken = 0; cmd_active = 0; wait_phase = 0; beat_valid = 0;
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 len", len_rdata, 0); chk("R1 tmo", tmo_rdata, 0);
    chk("R1 cnt", cnt_rdata, 0); chk("R1 data_en", data_en, 0);
    chk("R1 cmd_en", cmd_en, 0); chk("R1 done", done, 0);
    chk("R1 timeout", timeout_flag, 0); chk("R1 cfg_err", cfg_err, 0);
    chk("R5 ready idle", beat_ready, 0);

    // R2 reserved bits read zero
    wr_reg(1'b0, 32'hFFFF_FFFF);
    chk("R2 width", len_rdata, 32'h01FF_FFFF);
    wr_reg(1'b1, 32'hDEAD_BEEF);
    chk("R3 write", tmo_rdata, 32'hDEAD_BEEF);
    wr_reg(1'b1, 32'd0);

    // multibyte sweep, both rates
    for (int d = 0; d < 2; d++)
      for (int len = 0; len <= 40; len++) run_xfer(len, d[0], 1'b0, 0);
    // block sweep
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 4; k++)
        for (int len = 0; len <= 16; len++) run_xfer(len, d[0], 1'b1, k);
    // multibyte bounds
    run_xfer(512, 1'b0, 1'b0, 0);
    run_xfer(513, 1'b0, 1'b0, 0);
    run_xfer(513, 1'b1, 1'b0, 0);

    // R9 timeout sweep
    for (int t = 0; t < 6; t++) begin
      int n;
      n = (t == 0) ? 1 : t;
      wr_reg(1'b1, 32'(t));
      wr_reg(1'b0, 32'd10);
      ddr_mode = 0; block_mode = 0;
      pulse_start();
      chk("R9 cleared on start", timeout_flag, 0);
      chk("R9 running", data_en, 1);
      wait_phase = 1'b1;
      for (int j = 1; j < n; j++) begin
        tick();
        chk("R9 not yet", timeout_flag, 0);
      end
      tick();
      chk("R9 flag", timeout_flag, 1);
      chk("R9 stop", data_en, 0);
      wait_phase = 1'b0;
      tick();
      chk("R9 sticky", timeout_flag, 1);
    end
    // R9 reload on a broken wait
    wr_reg(1'b1, 32'd4);
    pulse_start();
    wait_phase = 1'b1;
    repeat (3) tick();
    wait_phase = 1'b0;
    tick();
    wait_phase = 1'b1;
    repeat (3) tick();
    chk("R9 reloaded", timeout_flag, 0);
    tick();
    chk("R9 reload expiry", timeout_flag, 1);
    wait_phase = 1'b0;

    // locks and busy start
    wr_reg(1'b1, 32'd3);
    wr_reg(1'b0, 32'd8);
    pulse_start();
    wr_reg(1'b0, 32'd99);
    chk("R2 locked", len_rdata, 8);
    wr_reg(1'b1, 32'd77);
    chk("R3 locked by data", tmo_rdata, 3);
    beat_valid = 1'b1; tick(); beat_valid = 1'b0;
    chk("R5 one beat", cnt_rdata, 7);
    pulse_start();
    chk("R10 busy start", cnt_rdata, 7);
    chk("R10 still running", data_en, 1);
    wait_phase = 1'b1;
    repeat (3) tick();
    wait_phase = 1'b0;
    chk("R9 abort", data_en, 0);
    cmd_active = 1'b1;
    wr_reg(1'b1, 32'd55);
    chk("R3 locked by cmd", tmo_rdata, 3);
    cmd_active = 1'b0;
    wr_reg(1'b1, 32'd55);
    chk("R3 idle write", tmo_rdata, 55);

    // command enable
    start_cmd = 1'b1; cmd_xfer = 1'b0; tick(); start_cmd = 1'b0;
    chk("R11 set", cmd_en, 1);
    cmd_taken = 1'b1; tick(); cmd_taken = 1'b0;
    chk("R11 taken", cmd_en, 0);
    wr_reg(1'b0, 32'd1);
    ddr_mode = 1'b1;
    start_cmd = 1'b1; cmd_xfer = 1'b1; tick(); start_cmd = 1'b0;
    chk("R7 cmd blocked ddr", cmd_en, 0);
    ddr_mode = 1'b0;
    start_cmd = 1'b1; tick(); start_cmd = 1'b0;
    chk("R11 set with data", cmd_en, 1);
    wr_reg(1'b0, 32'd0);
    pulse_start();
    chk("R7 abort cmd_en", cmd_en, 0);
    chk("R7 abort data_en", data_en, 0);

    finish_run();
  end
endmodule